// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Buffered Compare

This block is a 16-bit timer that counts up from zero to a ceiling value and then back down to zero, over and over. A single compare value, set against that triangle, produces a pulse-width-modulated output whose pulses are centred on the bottom of each cycle. This suits motor drives and other loads that are sensitive to harmonics. A clock-enable divider sets the count rate, and a register write port lets a host program the compare value, the ceiling value and the control fields.

Host writes to the compare and ceiling registers land in holding copies. The working copies take them up only at a chosen point in the cycle. Loading at the ceiling allows the fastest response, but a ceiling change then gives one lopsided cycle. Loading at the bottom keeps every cycle symmetric. The ceiling can come from its own register or from the compare register, and an output mode selects off, toggle, normal or complemented pulses. Three one-cycle flags mark the ceiling, the bottom and each compare hit.

Top module: `pwm_dual_slope`

## Requirements
- R1: After reset the counter is at zero and counting up. With a stable ceiling T and divide ratio N, the time from a bottom flag to the next ceiling flag is N*T clocks, and the time from a ceiling flag to the next bottom flag is also N*T clocks.
- R2: In output mode 2 (normal), with 0 < C < T, the output is high for 2*N*C clocks and low for 2*N*(T-C) clocks in each cycle. It drops when the counter reaches C while rising and goes high when the counter reaches C while falling.
- R3: In output mode 3 (complemented), with 0 < C < T, the output is high for 2*N*(T-C) clocks and low for 2*N*C clocks.
- R4: With control bit 5 clear, the working values load when the counter reaches the ceiling. After the ceiling changes from T1 to T2, the next falling slope lasts N*T1 clocks and the following rising slope lasts N*T2 clocks.
- R5: With control bit 5 set, the working values load when the counter reaches zero. After a ceiling change to T2, the next rising slope and the next falling slope both last N*T2 clocks.
- R6: A write to address 1 (compare) or address 2 (ceiling) only fills a holding copy. The output keeps using the old value until the next load point, and uses the new value after it. While the clock select is in a stopped code, the working copies follow the holding copies on every clock.
- R7: A compare value of 0 holds the output low in mode 2 and high in mode 3.
- R8: A compare value equal to or greater than the ceiling holds the output high in mode 2.
- R9: When control bit 6 is set, the ceiling is the compare value. In output mode 1 the output then inverts on each compare hit, which gives a square wave with 2*N*C clocks high and 2*N*C clocks low.
- R10: A ceiling value below 3 acts as 3.
- R11: Control bits [2:0] select the divide ratio: code 1 for 1, 2 for 8, 3 for 64, 4 for 256 and 5 for 1024. Codes 0, 6 and 7 stop the counter. Any change of this field restarts the divider.
- R12: In a stopped code the counter holds its value, no flags are raised and the output does not change.
- R13: Output mode 0 (control bits [4:3] = 0) holds the output low. This is also the state after reset.
- R14: Each flag lasts exactly one clock. In mode 2 with 0 < C < T, each full cycle has one ceiling flag and two compare flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 compare, 2 ceiling, 3 unused |
| wr_data | input | 16 | Write data; control uses bits [6:0] |
| pwm_out | output | 1 | Waveform output |
| top_pulse | output | 1 | One-clock flag, counter reached the ceiling |
| bottom_pulse | output | 1 | One-clock flag, counter reached zero |
| match_pulse | output | 1 | One-clock flag, counter reached the compare value |

## Verification
If the direction bit or the count is wrong, the spacing between ceiling and bottom flags changes within one slope. A swapped set/clear rule or a wrong boundary test changes the output's high and low times by the end of the next full cycle. A load at the wrong point is visible in the first cycle after a ceiling or compare write, as one slope of the wrong length or one pulse edge in the wrong place. A divider fault multiplies every measured interval by the wrong factor.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  // packed: first field is the most significant
  typedef struct packed {
    logic      top_from_cmp;  // bit 6
    logic      upd_at_bottom; // bit 5
    out_mode_e mode;          // bits 4:3
    logic [2:0] clk_sel;      // bits 2:0
  } ctrl_t;

  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned MIN_TOP = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_TOP  = 2'd2;

  // divide ratio for a select code; 0 means stopped
  function automatic int unsigned divider_ratio(logic [2:0] sel);
    case (sel)
      3'd1:    return 1;
      3'd2:    return 8;
      3'd3:    return 64;
      3'd4:    return 256;
      3'd5:    return 1024;
      default: return 0;
    endcase
  endfunction

  // ceiling never below the minimum resolution
  function automatic logic [31:0] clamp_top(logic [31:0] v);
    return (v < MIN_TOP) ? MIN_TOP : v;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_dual_pkg::*;
#(
  parameter int unsigned MAX_DIV = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick,
  output logic       stopped
);
  localparam int unsigned DW = $clog2(MAX_DIV);

  logic [DW-1:0] div_q;
  logic [2:0]    sel_q;
  int unsigned   ratio;
  logic          sel_chg;

  always_comb begin
    ratio   = divider_ratio(sel);
    stopped = (ratio == 0);
    sel_chg = (sel != sel_q);
    tick    = !stopped && !sel_chg && (32'(div_q) == ratio - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel;
      if (sel_chg || stopped || tick) div_q <= '0;
      else                            div_q <= div_q + 1'b1;
    end
  end

  // R11: a select change never produces a tick in the same cycle
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !tick);

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dual_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         load_evt,
  output ctrl_t        ctrl,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] top_act,
  output logic [W-1:0] cmp_nxt,
  output logic [W-1:0] top_nxt
);
  logic [W-1:0] cmp_buf, top_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cmp_buf <= '0;
      top_buf <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_CMP:  cmp_buf <= wr_data;
        ADDR_TOP:  top_buf <= wr_data;
        default:   ;
      endcase
    end
  end

  // values in force after this edge
  always_comb begin
    cmp_nxt = load_evt ? cmp_buf : cmp_act;
    top_nxt = load_evt ? top_buf : top_act;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act <= '0;
      top_act <= '1;
    end else begin
      cmp_act <= cmp_nxt;
      top_act <= top_nxt;
    end
  end

  // R6: working copies move only at a load point
  assert_buffered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(cmp_act) && $stable(top_act)));

endmodule

// File: rtl/pwm_updown.sv
module pwm_updown #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         stopped,
  input  logic         upd_at_bottom,
  input  logic [W-1:0] top_now,
  output logic [W-1:0] cnt,
  output logic         count_up,
  output logic [W-1:0] nxt_cnt,
  output logic         load_evt,
  output logic         top_pulse,
  output logic         bottom_pulse
);
  logic nxt_up, top_hit, bottom_hit;

  always_comb begin
    nxt_cnt    = cnt;
    nxt_up     = count_up;
    top_hit    = 1'b0;
    bottom_hit = 1'b0;
    if (tick) begin
      if (count_up) begin
        if (cnt >= top_now) begin
          // ceiling moved below the count while stopped: turn without a flag
          nxt_cnt = cnt - 1'b1;
          nxt_up  = 1'b0;
        end else begin
          nxt_cnt = cnt + 1'b1;
          if (cnt == top_now - 1'b1) begin
            nxt_up  = 1'b0;
            top_hit = 1'b1;
          end
        end
      end else if (cnt <= W'(1)) begin
        nxt_cnt    = '0;
        nxt_up     = 1'b1;
        bottom_hit = 1'b1;
      end else begin
        nxt_cnt = cnt - 1'b1;
      end
    end
    load_evt = stopped || (upd_at_bottom ? bottom_hit : top_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      count_up     <= 1'b1;
      top_pulse    <= 1'b0;
      bottom_pulse <= 1'b0;
    end else begin
      cnt          <= nxt_cnt;
      count_up     <= nxt_up;
      top_pulse    <= top_hit;
      bottom_pulse <= bottom_hit;
    end
  end

  // R1: each tick moves the count by exactly one
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));
  // R1: bottom flag coincides with a zero count heading up
  assert_bottom_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bottom_pulse |-> (cnt == '0 && count_up));
  // R12: no tick, no movement
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R14: flags are single-cycle and never together
  assert_top_width_R14: assert property (@(posedge clk) disable iff (!rst_n)
    top_pulse |=> !top_pulse);
  assert_flag_excl_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_pulse && bottom_pulse));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_dual_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         step_up,
  input  logic [W-1:0] nxt_cnt,
  input  logic [W-1:0] cmp_next,
  input  logic [W-1:0] top_next,
  input  out_mode_e    mode,
  output logic         pwm_out,
  output logic         match_pulse
);
  logic match, raw_q, tog_q, raw_d;

  always_comb begin
    match = tick && (nxt_cnt == cmp_next);
    raw_d = raw_q;
    if (tick) begin
      if (cmp_next == '0)            raw_d = 1'b0;
      else if (cmp_next >= top_next) raw_d = 1'b1;
      else if (match)                raw_d = !step_up;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q       <= 1'b0;
      tog_q       <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      raw_q       <= raw_d;
      tog_q       <= tog_q ^ match;
      match_pulse <= match;
    end
  end

  always_comb begin
    case (mode)
      OUT_TOGGLE: pwm_out = tog_q;
      OUT_NONINV: pwm_out = raw_q;
      OUT_INV:    pwm_out = !raw_q;
      default:    pwm_out = 1'b0;
    endcase
  end

  // R7: zero compare pins the normal waveform low after a tick
  assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_next == '0) |=> !raw_q);
  // R8: compare at or over the ceiling pins it high
  assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_next != '0 && cmp_next >= top_next) |=> raw_q);
  // R9: toggle register moves only on a compare flag
  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !match_pulse |-> $stable(tog_q));

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_dual_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned MAX_DIV = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic         top_pulse,
  output logic         bottom_pulse,
  output logic         match_pulse
);
  ctrl_t        ctrl;
  logic         tick, stopped, load_evt, count_up;
  logic [W-1:0] cmp_act, top_act, cmp_nxt, top_nxt;
  logic [W-1:0] top_now, top_next, cnt, nxt_cnt;

  pwm_prescaler #(.MAX_DIV(MAX_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .sel(ctrl.clk_sel),
    .tick(tick), .stopped(stopped)
  );

  pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_evt(load_evt), .ctrl(ctrl),
    .cmp_act(cmp_act), .top_act(top_act),
    .cmp_nxt(cmp_nxt), .top_nxt(top_nxt)
  );

  // ceiling source and minimum resolution
  always_comb begin
    top_now  = W'(clamp_top(32'(ctrl.top_from_cmp ? cmp_act : top_act)));
    top_next = W'(clamp_top(32'(ctrl.top_from_cmp ? cmp_nxt : top_nxt)));
  end

  pwm_updown #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stopped(stopped),
    .upd_at_bottom(ctrl.upd_at_bottom), .top_now(top_now),
    .cnt(cnt), .count_up(count_up), .nxt_cnt(nxt_cnt),
    .load_evt(load_evt), .top_pulse(top_pulse), .bottom_pulse(bottom_pulse)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_up(count_up),
    .nxt_cnt(nxt_cnt), .cmp_next(cmp_nxt), .top_next(top_next),
    .mode(ctrl.mode), .pwm_out(pwm_out), .match_pulse(match_pulse)
  );

  // R10: the ceiling in use is never below three
  assert_min_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    top_pulse |-> (cnt >= W'(MIN_TOP)));

endmodule

// File: tb/pwm_dual_slope_test.sv
`timescale 1ns/1ps
module pwm_dual_slope_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, top_pulse, bottom_pulse, match_pulse;

  always #2.5 clk = ~clk;

  pwm_dual_slope uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .top_pulse(top_pulse),
    .bottom_pulse(bottom_pulse), .match_pulse(match_pulse)
  );

  localparam int K_HL = 0, K_RF = 1, K_FR = 2, K_LEVEL = 3,
                 K_QUIET = 4, K_BFALL = 5, K_MATCH = 6;

  typedef struct {
    int    kind;
    int    a;
    int    b;
    string tag;
  } item_t;

  item_t q[$];
  bit    busy = 0;
  int    checks = 0, errors = 0, cyc = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(int sel, int mode, int at_bottom, int from_cmp);
    return 16'((from_cmp << 6) | (at_bottom << 5) | (mode << 3) | sel);
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_top();
    do @(negedge clk); while (!top_pulse);
  endtask
  task automatic wait_bottom();
    do @(negedge clk); while (!bottom_pulse);
  endtask
  task automatic count_to_top(output int n);
    n = 0; do begin @(negedge clk); n++; end while (!top_pulse);
  endtask
  task automatic count_to_bottom(output int n);
    n = 0; do begin @(negedge clk); n++; end while (!bottom_pulse);
  endtask
  task automatic count_to_level(logic lv, output int n);
    n = 0; do begin @(negedge clk); n++; end while (pwm_out != lv);
  endtask

  // monitor: pops an expectation, measures the ports, compares
  task automatic run_item(item_t it);
    int n1, n2, bad, tops, mt;
    logic prev;
    case (it.kind)
      K_HL: begin
        prev = pwm_out;
        do begin prev = pwm_out; @(negedge clk); end while (!(pwm_out && !prev));
        count_to_level(1'b0, n1);
        count_to_level(1'b1, n2);
        check(n1 == it.a, it.tag, "high time", n1, it.a);
        check(n2 == it.b, it.tag, "low time", n2, it.b);
      end
      K_RF: begin
        wait_bottom(); count_to_top(n1); count_to_bottom(n2);
        check(n1 == it.a, it.tag, "rising slope", n1, it.a);
        check(n2 == it.b, it.tag, "falling slope", n2, it.b);
      end
      K_FR: begin
        wait_top(); count_to_bottom(n1); count_to_top(n2);
        check(n1 == it.a, it.tag, "falling slope", n1, it.a);
        check(n2 == it.b, it.tag, "rising slope", n2, it.b);
      end
      K_LEVEL: begin
        bad = 0;
        for (int i = 0; i < it.a; i++) begin
          @(negedge clk);
          if (pwm_out != it.b[0]) bad++;
        end
        check(bad == 0, it.tag, "cycles off level", bad, 0);
      end
      K_QUIET: begin
        bad = 0; prev = pwm_out;
        for (int i = 0; i < it.a; i++) begin
          @(negedge clk);
          if (top_pulse || bottom_pulse || match_pulse || pwm_out != prev) bad++;
        end
        check(bad == 0, it.tag, "activity while stopped", bad, 0);
      end
      K_BFALL: begin
        wait_bottom(); count_to_level(1'b0, n1);
        check(n1 == it.a, it.tag, "bottom to fall", n1, it.a);
      end
      K_MATCH: begin
        wait_bottom(); tops = 0; mt = 0;
        do begin
          @(negedge clk);
          if (top_pulse) tops++;
          if (match_pulse) mt++;
        end while (!bottom_pulse);
        check(mt == it.a, it.tag, "compare flag cycles", mt, it.a);
        check(tops == it.b, it.tag, "ceiling flag cycles", tops, it.b);
      end
      default: ;
    endcase
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        busy = 1;
        run_item(it);
        busy = 0;
      end
    end
  end

  task automatic push(int kind, int a, int b, string tag);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0 || busy);
  endtask

  task automatic setup(int sel, int mode, int at_bottom, int from_cmp, int c, int t);
    wr(2'd0, ctl(0, mode, at_bottom, from_cmp));
    wr(2'd1, 16'(c));
    wr(2'd2, 16'(t));
    wr(2'd0, ctl(sel, mode, at_bottom, from_cmp));
    wait_bottom(); wait_bottom();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state, output low and no flags
    check(pwm_out == 1'b0, "R13", "reset output", int'(pwm_out), 0);
    check({top_pulse, bottom_pulse, match_pulse} == 3'b000, "R13", "reset flags",
          int'({top_pulse, bottom_pulse, match_pulse}), 0);
    // R12: stopped after reset
    push(K_QUIET, 60, 0, "R12"); drain();

    // R2, R1, R14: normal mode, ratio 1, T=20, C=5
    setup(1, 2, 0, 0, 5, 20);
    push(K_HL, 10, 30, "R2");
    push(K_RF, 20, 20, "R1");
    push(K_MATCH, 2, 1, "R14");
    drain();

    // R3: complemented mode
    setup(1, 3, 0, 0, 5, 20);
    push(K_HL, 30, 10, "R3"); drain();

    // R11: divide ratios
    setup(2, 2, 0, 0, 4, 10);
    push(K_HL, 64, 96, "R11"); drain();
    setup(3, 2, 0, 0, 2, 5);
    push(K_RF, 320, 320, "R11"); drain();
    setup(4, 2, 0, 0, 1, 4);
    push(K_HL, 512, 1536, "R11"); drain();
    setup(5, 2, 0, 0, 1, 3);
    push(K_RF, 3072, 3072, "R11"); drain();

    // R4: load at ceiling gives one lopsided cycle
    setup(1, 2, 0, 0, 10, 40);
    wait_bottom();
    push(K_FR, 40, 30, "R4");
    wr(2'd2, 16'd30);
    drain();

    // R5: load at bottom keeps both slopes equal
    setup(1, 2, 1, 0, 10, 40);
    wait_top();
    push(K_RF, 30, 30, "R5");
    wr(2'd2, 16'd30);
    drain();

    // R6: compare write waits for the load point
    setup(1, 2, 0, 0, 20, 60);
    wait_top();
    push(K_BFALL, 20, 0, "R6");
    wait_bottom();
    wr(2'd1, 16'd40);
    drain();
    wait_bottom(); wait_bottom();
    push(K_HL, 80, 40, "R6"); drain();

    // R7: zero compare
    setup(1, 2, 0, 0, 0, 20);
    push(K_LEVEL, 200, 0, "R7"); drain();
    setup(1, 3, 0, 0, 0, 20);
    push(K_LEVEL, 200, 1, "R7"); drain();

    // R8: compare at and above the ceiling
    setup(1, 2, 0, 0, 20, 20);
    push(K_LEVEL, 200, 1, "R8"); drain();
    setup(1, 2, 0, 0, 25, 20);
    push(K_LEVEL, 200, 1, "R8"); drain();

    // R9: ceiling from compare, toggle output
    setup(1, 1, 0, 1, 10, 50);
    push(K_HL, 20, 20, "R9"); drain();

    // R10: ceiling 1 acts as 3
    setup(1, 2, 0, 0, 0, 1);
    push(K_RF, 3, 3, "R10"); drain();

    // R13: output off while running
    setup(1, 0, 0, 0, 5, 20);
    push(K_LEVEL, 100, 0, "R13"); drain();

    // R12: stop mid-run
    setup(1, 2, 0, 0, 5, 20);
    wr(2'd0, ctl(0, 2, 0, 0));
    repeat (3) @(negedge clk);
    push(K_QUIET, 300, 0, "R12"); drain();

    summary();
  end
endmodule